// File: doc/BRIEF.md
# Auxiliary Packet Framer and Checker

This block handles the short control packets exchanged on a side channel next to a main data link. On the transmit side it accepts a payload as a byte stream whose first byte is the packet type code. It passes the payload through, adds zero bytes until the frame length is a multiple of four, and appends a 32-bit checksum computed over everything sent before it. When the last checksum byte leaves, it reports the total frame length.

On the receive side it takes a completed frame as a byte stream marked with a last flag. It counts the bytes and keeps the newest four in a small shift line, so the checksum is computed over every byte except the trailing four. The verdict is given one cycle after the last byte. A frame is too short, has a bad checksum, has an unknown type code, or is valid, in which case the type code comes with it. Exactly one of these outcomes is pulsed, together with a done strobe and the received length.

Both directions move one byte per cycle with valid/ready handshakes. Link serialization, buffer storage and request/reply handling belong to the surrounding logic.

Top module: `lnkaux_frame_unit`

## Requirements
- R1: Type code 0 (echo request) and type code 1 (echo reply) are the only accepted codes. A frame that passes the length and checksum checks with any other code in byte 0 raises `rx_err_type`.
- R2: The transmit output repeats the payload bytes unchanged and in order. It then emits 0x00 bytes until the byte count is a multiple of 4, and emits none when the payload length is already a multiple of 4.
- R3: The appended checksum is the reflected CRC-32 with polynomial 0xEDB88320, initial value 0xFFFFFFFF and final XOR 0xFFFFFFFF. It covers the payload and the padding and is sent most significant byte first. `tx_out_last` is high only on the fourth checksum byte.
- R4: One cycle after the final checksum byte is accepted, `tx_len_valid` pulses for one cycle. At that point `tx_len` equals the padded length plus 4, which is always a multiple of 4 and at least 8.
- R5: While `tx_out_ready` is low, no byte is lost. During padding and checksum output, `tx_out_data` holds steady. During the payload, `tx_in_ready` follows `tx_out_ready`.
- R6: A received frame of fewer than 8 bytes gives `rx_err_short` and no other outcome, whatever its content.
- R7: For a frame of at least 8 bytes, the CRC-32 of R3 is computed over all bytes except the final four and compared with those four bytes read most significant first. A difference gives `rx_err_crc`.
- R8: The type code is judged only after the checksum matches. A valid frame gives `rx_ok` with `rx_type` equal to byte 0. A frame with a bad checksum reports `rx_err_crc` even when its type code is unknown.
- R9: `rx_done` pulses for one cycle, one cycle after the last byte is accepted. With it, exactly one of `rx_ok`, `rx_err_short`, `rx_err_crc`, `rx_err_type` is high, and `rx_len` holds the 16-bit byte count. When `rx_done` is low, all four are low.
- R10: After reset no transmit byte, length report or receive result is pending, and `tx_in_ready` follows `tx_out_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_in_valid | input | 1 | Payload byte valid |
| tx_in_ready | output | 1 | Payload byte accepted |
| tx_in_data | input | 8 | Payload byte; the first is the type code |
| tx_in_last | input | 1 | Marks the final payload byte |
| tx_out_valid | output | 1 | Framed byte valid |
| tx_out_ready | input | 1 | Downstream accepts the framed byte |
| tx_out_data | output | 8 | Framed byte |
| tx_out_last | output | 1 | Marks the final checksum byte |
| tx_len_valid | output | 1 | One-cycle frame length report |
| tx_len | output | 16 | Total framed length in bytes |
| rx_in_valid | input | 1 | Received byte valid |
| rx_in_ready | output | 1 | Received byte accepted (always high) |
| rx_in_data | input | 8 | Received byte |
| rx_in_last | input | 1 | Marks the final received byte |
| rx_done | output | 1 | One-cycle verdict strobe |
| rx_len | output | 16 | Received byte count |
| rx_ok | output | 1 | Frame valid |
| rx_type | output | 8 | Type code of a valid frame |
| rx_err_short | output | 1 | Frame under 8 bytes |
| rx_err_crc | output | 1 | Checksum mismatch |
| rx_err_type | output | 1 | Unknown type code |

## Verification
The transmitter is driven with every payload length from 1 to 9 under irregular input gaps and output stalls. This separates the aligned case with no padding from one, two and three pad bytes, and tests that backpressure drops nothing. Each transmitted frame is looped back into the receiver, and the receiver is also swept over all 256 type codes in correct frames, which separates the two accepted codes from every rejected one. Frames of 1 to 7 bytes with otherwise correct checksums isolate the length rule. Single-bit flips across all 64 bits of an 8-byte frame and a known checksum vector isolate the checksum comparison and its priority over the type check.

// File: rtl/lnkaux_pkg.sv
package lnkaux_pkg;
    localparam int BYTE_W    = 8;
    localparam int CRC_W     = 32;
    localparam int CRC_BYTES = CRC_W / BYTE_W;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;
    localparam logic [CRC_W-1:0] CRC_INIT = 32'hFFFFFFFF;
    localparam logic [CRC_W-1:0] CRC_XOUT = 32'hFFFFFFFF;

    typedef enum logic [1:0] {
        TX_PAY = 2'd0,
        TX_PAD = 2'd1,
        TX_CRC = 2'd2
    } tx_state_e;
endpackage

// File: rtl/lnkaux_crc32_step.sv
module lnkaux_crc32_step
    import lnkaux_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY = CRC_POLY
) (
    input  logic [CRC_W-1:0]  crc_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [CRC_W-1:0]  crc_o
);
    // one unrolled shift stage per input bit, least significant bit first
    logic [CRC_W-1:0] stage [BYTE_W+1];

    assign stage[0] = crc_i ^ {{(CRC_W-BYTE_W){1'b0}}, byte_i};

    generate
        for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
            assign stage[b+1] = stage[b][0] ? ((stage[b] >> 1) ^ POLY)
                                            : (stage[b] >> 1);
        end
    endgenerate

    assign crc_o = stage[BYTE_W];
endmodule

// File: rtl/lnkaux_tx_framer.sv
module lnkaux_tx_framer
    import lnkaux_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int ALIGN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_last,
    output logic              len_valid,
    output logic [LEN_W-1:0]  len
);
    localparam int ALIGN_W = $clog2(ALIGN);
    localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};
    localparam int IDX_W = $clog2(CRC_BYTES);

    typedef struct packed {
        tx_state_e        st;
        logic [LEN_W-1:0] cnt;
        logic [CRC_W-1:0] crc;
        logic [IDX_W-1:0] idx;
        logic             len_vld;
        logic [LEN_W-1:0] len;
    } tx_reg_t;

    tx_reg_t q, d;

    logic [CRC_W-1:0]  crc_nxt;
    logic [CRC_W-1:0]  crc_fin;
    logic [LEN_W-1:0]  cnt_inc;
    logic [LEN_W:0]    len_sum;
    logic              aligned_after;
    logic [BYTE_W-1:0] byte_sel;
    logic [BYTE_W-1:0] crc_byte;

    lnkaux_crc32_step #(.POLY(CRC_POLY)) i_crc (
        .crc_i (q.crc),
        .byte_i(byte_sel),
        .crc_o (crc_nxt)
    );

    always_comb begin
        d             = q;
        d.len_vld     = 1'b0;
        cnt_inc       = (q.cnt == LEN_MAX) ? q.cnt : q.cnt + 1'b1;
        aligned_after = (cnt_inc[ALIGN_W-1:0] == '0);
        crc_fin       = q.crc ^ CRC_XOUT;
        len_sum       = {1'b0, q.cnt} + (LEN_W+1)'(CRC_BYTES);
        case (q.idx)
            2'd0:    crc_byte = crc_fin[31:24];
            2'd1:    crc_byte = crc_fin[23:16];
            2'd2:    crc_byte = crc_fin[15:8];
            default: crc_byte = crc_fin[7:0];
        endcase

        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_last  = 1'b0;
        byte_sel  = '0;

        case (q.st)
            TX_PAY: begin
                in_ready  = out_ready;
                out_valid = in_valid;
                byte_sel  = in_data;
                if (in_valid && out_ready) begin
                    d.cnt = cnt_inc;
                    d.crc = crc_nxt;
                    if (in_last) begin
                        d.st = aligned_after ? TX_CRC : TX_PAD;
                    end
                end
            end
            TX_PAD: begin
                out_valid = 1'b1;
                byte_sel  = '0;
                if (out_ready) begin
                    d.cnt = cnt_inc;
                    d.crc = crc_nxt;
                    if (aligned_after) begin
                        d.st = TX_CRC;
                    end
                end
            end
            default: begin
                out_valid = 1'b1;
                byte_sel  = crc_byte;
                out_last  = (q.idx == IDX_W'(CRC_BYTES-1));
                if (out_ready) begin
                    if (out_last) begin
                        d.st      = TX_PAY;
                        d.cnt     = '0;
                        d.crc     = CRC_INIT;
                        d.idx     = '0;
                        d.len_vld = 1'b1;
                        d.len     = len_sum[LEN_W] ? LEN_MAX : len_sum[LEN_W-1:0];
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
            end
        endcase
    end

    assign out_data  = byte_sel;
    assign len_valid = q.len_vld;
    assign len       = q.len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st      <= TX_PAY;
            q.cnt     <= '0;
            q.crc     <= CRC_INIT;
            q.idx     <= '0;
            q.len_vld <= 1'b0;
            q.len     <= '0;
        end else begin
            q <= d;
        end
    end

    // R4: every reported length is aligned and covers at least one word plus checksum
    p_len_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        len_valid |-> (len[ALIGN_W-1:0] == '0) && (len >= LEN_W'(ALIGN + CRC_BYTES)));

    // R4: final checksum byte accepted -> length report on the next cycle
    p_len_follows_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> len_valid);

    // R5: padding and checksum bytes hold while stalled
    p_hold_stalled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && q.st != TX_PAY) |=> (out_valid && $stable(out_data)));

    // R3: last is marked only on a byte that is actually offered
    p_last_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);
endmodule

// File: rtl/lnkaux_rx_checker.sv
module lnkaux_rx_checker
    import lnkaux_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int MIN_LEN   = 8,
    parameter int NUM_TYPES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    output logic              done,
    output logic [LEN_W-1:0]  len,
    output logic              ok,
    output logic [BYTE_W-1:0] typ,
    output logic              err_short,
    output logic              err_crc,
    output logic              err_type
);
    localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};

    typedef struct packed {
        logic [LEN_W-1:0]  cnt;
        logic [CRC_W-1:0]  crc;
        logic [CRC_W-1:0]  dly;
        logic [BYTE_W-1:0] first;
        logic              done;
        logic [LEN_W-1:0]  len;
        logic              ok;
        logic [BYTE_W-1:0] typ;
        logic              e_short;
        logic              e_crc;
        logic              e_type;
    } rx_reg_t;

    rx_reg_t q, d;

    logic [CRC_W-1:0]  crc_step_o;
    logic [CRC_W-1:0]  crc_upd;
    logic [CRC_W-1:0]  dly_next;
    logic [LEN_W-1:0]  cnt_inc;
    logic [BYTE_W-1:0] type_byte;
    logic              crc_match;
    logic              is_short;
    logic              known_type;

    // the byte leaving the four-byte line is the oldest one, never part of the trailer
    lnkaux_crc32_step #(.POLY(CRC_POLY)) i_crc (
        .crc_i (q.crc),
        .byte_i(q.dly[CRC_W-1 -: BYTE_W]),
        .crc_o (crc_step_o)
    );

    always_comb begin
        d          = q;
        d.done     = 1'b0;
        d.ok       = 1'b0;
        d.e_short  = 1'b0;
        d.e_crc    = 1'b0;
        d.e_type   = 1'b0;
        cnt_inc    = (q.cnt == LEN_MAX) ? q.cnt : q.cnt + 1'b1;
        crc_upd    = (q.cnt >= LEN_W'(CRC_BYTES)) ? crc_step_o : q.crc;
        dly_next   = {q.dly[CRC_W-BYTE_W-1:0], in_data};
        type_byte  = (q.cnt == '0) ? in_data : q.first;
        crc_match  = ((crc_upd ^ CRC_XOUT) == dly_next);
        is_short   = (cnt_inc < LEN_W'(MIN_LEN));
        known_type = (int'(type_byte) < NUM_TYPES);

        if (in_valid) begin
            if (in_last) begin
                d.cnt     = '0;
                d.crc     = CRC_INIT;
                d.dly     = '0;
                d.first   = '0;
                d.done    = 1'b1;
                d.len     = cnt_inc;
                d.e_short = is_short;
                d.e_crc   = !is_short && !crc_match;
                d.e_type  = !is_short && crc_match && !known_type;
                d.ok      = !is_short && crc_match && known_type;
                if (!is_short && crc_match && known_type) begin
                    d.typ = type_byte;
                end
            end else begin
                d.cnt = cnt_inc;
                d.crc = crc_upd;
                d.dly = dly_next;
                if (q.cnt == '0) begin
                    d.first = in_data;
                end
            end
        end
    end

    assign in_ready  = 1'b1;
    assign done      = q.done;
    assign len       = q.len;
    assign ok        = q.ok;
    assign typ       = q.typ;
    assign err_short = q.e_short;
    assign err_crc   = q.e_crc;
    assign err_type  = q.e_type;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.cnt     <= '0;
            q.crc     <= CRC_INIT;
            q.dly     <= '0;
            q.first   <= '0;
            q.done    <= 1'b0;
            q.len     <= '0;
            q.ok      <= 1'b0;
            q.typ     <= '0;
            q.e_short <= 1'b0;
            q.e_crc   <= 1'b0;
            q.e_type  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    // R9: exactly one outcome with each verdict
    p_one_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($countones({ok, err_short, err_crc, err_type}) == 1));

    // R9: outcomes stay low between verdicts
    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> !(ok || err_short || err_crc || err_type));

    // R9: last byte accepted -> verdict on the next cycle
    p_verdict_timing_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last) |=> done);

    // R6: length alone decides the short outcome
    p_short_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (err_short == (len < LEN_W'(MIN_LEN))));

    // R1: an accepted frame carries a known code
    p_ok_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ok |-> (int'(typ) < NUM_TYPES));
endmodule

// File: rtl/lnkaux_frame_unit.sv
module lnkaux_frame_unit
    import lnkaux_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int ALIGN     = 4,
    parameter int MIN_LEN   = 8,
    parameter int NUM_TYPES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_in_valid,
    output logic             tx_in_ready,
    input  logic [7:0]       tx_in_data,
    input  logic             tx_in_last,
    output logic             tx_out_valid,
    input  logic             tx_out_ready,
    output logic [7:0]       tx_out_data,
    output logic             tx_out_last,
    output logic             tx_len_valid,
    output logic [LEN_W-1:0] tx_len,
    input  logic             rx_in_valid,
    output logic             rx_in_ready,
    input  logic [7:0]       rx_in_data,
    input  logic             rx_in_last,
    output logic             rx_done,
    output logic [LEN_W-1:0] rx_len,
    output logic             rx_ok,
    output logic [7:0]       rx_type,
    output logic             rx_err_short,
    output logic             rx_err_crc,
    output logic             rx_err_type
);
    lnkaux_tx_framer #(
        .LEN_W(LEN_W),
        .ALIGN(ALIGN)
    ) i_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (tx_in_valid),
        .in_ready (tx_in_ready),
        .in_data  (tx_in_data),
        .in_last  (tx_in_last),
        .out_valid(tx_out_valid),
        .out_ready(tx_out_ready),
        .out_data (tx_out_data),
        .out_last (tx_out_last),
        .len_valid(tx_len_valid),
        .len      (tx_len)
    );

    lnkaux_rx_checker #(
        .LEN_W    (LEN_W),
        .MIN_LEN  (MIN_LEN),
        .NUM_TYPES(NUM_TYPES)
    ) i_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (rx_in_valid),
        .in_ready (rx_in_ready),
        .in_data  (rx_in_data),
        .in_last  (rx_in_last),
        .done     (rx_done),
        .len      (rx_len),
        .ok       (rx_ok),
        .typ      (rx_type),
        .err_short(rx_err_short),
        .err_crc  (rx_err_crc),
        .err_type (rx_err_type)
    );
endmodule

// File: tb/test_lnkaux_frame_unit.sv
`timescale 1ns/1ps
module test_lnkaux_frame_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_in_valid = 1'b0, tx_in_last = 1'b0, tx_out_ready = 1'b0;
    logic [7:0]  tx_in_data = '0;
    logic        tx_in_ready, tx_out_valid, tx_out_last, tx_len_valid;
    logic [7:0]  tx_out_data;
    logic [15:0] tx_len;
    logic        rx_in_valid = 1'b0, rx_in_last = 1'b0;
    logic [7:0]  rx_in_data = '0;
    logic        rx_in_ready, rx_done, rx_ok, rx_err_short, rx_err_crc, rx_err_type;
    logic [15:0] rx_len;
    logic [7:0]  rx_type;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] fb  [0:63];
    logic [7:0] exb [0:63];

    always #2 clk = ~clk;

    lnkaux_frame_unit i_lnkaux_frame_unit (
        .clk(clk), .rst_n(rst_n),
        .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready), .tx_in_data(tx_in_data),
        .tx_in_last(tx_in_last), .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready),
        .tx_out_data(tx_out_data), .tx_out_last(tx_out_last), .tx_len_valid(tx_len_valid),
        .tx_len(tx_len), .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready),
        .rx_in_data(rx_in_data), .rx_in_last(rx_in_last), .rx_done(rx_done), .rx_len(rx_len),
        .rx_ok(rx_ok), .rx_type(rx_type), .rx_err_short(rx_err_short),
        .rx_err_crc(rx_err_crc), .rx_err_type(rx_err_type)
    );

    task automatic check(input bit good, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input logic [7:0] a [0:63], input int n);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int i = 0; i < n; i++) begin
            c = c ^ {24'd0, a[i]};
            for (int b = 0; b < 8; b++) begin
                c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
            end
        end
        return c ^ 32'hFFFFFFFF;
    endfunction

    // place a checksum over the first n bytes of fb at fb[n..n+3], MSB first
    task automatic seal_fb(input int n);
        logic [31:0] c = ref_crc(fb, n);
        for (int k = 0; k < 4; k++) fb[n+k] = c[31-8*k -: 8];
    endtask

    // code: 0 ok, 1 short, 2 crc, 3 type
    task automatic feed_rx(input int n, input int code, input logic [7:0] etype,
                           input string tag);
        int  i = 0;
        int  cyc = 0;
        bit  spur = 0;
        logic [3:0] expf = 4'b1000 >> code;
        while (i < n) begin
            @(negedge clk);
            if (rx_done) spur = 1;
            rx_in_valid = ((cyc % 4) != 3);
            rx_in_data  = fb[i];
            rx_in_last  = (i == n - 1);
            #0.5;
            if (rx_in_valid && rx_in_ready) i++;
            cyc++;
        end
        @(negedge clk);
        rx_in_valid = 1'b0;
        rx_in_last  = 1'b0;
        #0.5;
        check(rx_done === 1'b1, {tag, " R9 verdict strobe"}, 32'(rx_done), 1);
        check({rx_ok, rx_err_short, rx_err_crc, rx_err_type} === expf, {tag, " outcome"},
              32'({rx_ok, rx_err_short, rx_err_crc, rx_err_type}), 32'(expf));
        check(rx_len === 16'(n), {tag, " R9 length"}, 32'(rx_len), n);
        if (code == 0) check(rx_type === etype, {tag, " R8 type"}, 32'(rx_type), 32'(etype));
        check(!spur, {tag, " R9 no early verdict"}, 32'(spur), 0);
    endtask

    task automatic run_tx(input int n, input logic [7:0] seed);
        int padded = ((n + 3) / 4) * 4;
        int total  = padded + 4;
        int sent = 0, got = 0, cyc = 0, bad = 0;
        bit fin = 0, badlast = 0;
        logic [31:0] c;
        for (int i = 0; i < 64; i++) exb[i] = 8'h00;
        for (int i = 0; i < n; i++) exb[i] = seed + 8'(37 * i);
        c = ref_crc(exb, padded);
        for (int k = 0; k < 4; k++) exb[padded+k] = c[31-8*k -: 8];
        while (!fin) begin
            @(negedge clk);
            tx_in_valid  = (sent < n) && ((cyc % 3) != 2);
            tx_in_data   = seed + 8'(37 * sent);
            tx_in_last   = (sent == n - 1);
            tx_out_ready = ((cyc % 4) != 1);
            #0.5;
            if (tx_in_valid && tx_in_ready) sent++;
            if (tx_out_valid && tx_out_ready) begin
                if (tx_out_data !== exb[got]) bad++;
                if (tx_out_last !== (got == total - 1)) badlast = 1;
                fb[got] = tx_out_data;
                got++;
                if (tx_out_last || got >= 64) fin = 1;
            end
            cyc++;
        end
        @(negedge clk);
        tx_in_valid  = 1'b0;
        tx_in_last   = 1'b0;
        tx_out_ready = 1'b0;
        #0.5;
        check(bad == 0, $sformatf("R2 R3 frame bytes n=%0d", n), bad, 0);
        check(!badlast, $sformatf("R3 last flag n=%0d", n), 32'(badlast), 0);
        check(got == total && sent == n, $sformatf("R5 byte count n=%0d", n), got, total);
        check(tx_len_valid === 1'b1, $sformatf("R4 length strobe n=%0d", n),
              32'(tx_len_valid), 1);
        check(tx_len === 16'(total), $sformatf("R4 length n=%0d", n), 32'(tx_len), total);
        @(negedge clk);
        check(tx_len_valid === 1'b0, $sformatf("R4 single pulse n=%0d", n),
              32'(tx_len_valid), 0);
        // loop back into the receiver
        feed_rx(total, (exb[0] < 2) ? 0 : 3, exb[0], $sformatf("R1 loopback n=%0d", n));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        tx_out_ready = 1'b1;
        #0.5;
        check(tx_out_valid === 1'b0 && tx_len_valid === 1'b0 && rx_done === 1'b0,
              "R10 idle after reset", 32'({tx_out_valid, tx_len_valid, rx_done}), 0);
        check(tx_in_ready === 1'b1, "R10 ready follows downstream", 32'(tx_in_ready), 1);
        tx_out_ready = 1'b0;
        #0.5;
        check(tx_in_ready === 1'b0, "R5 ready drops with downstream", 32'(tx_in_ready), 0);

        // bench checksum anchored on the standard check value
        for (int i = 0; i < 9; i++) fb[i] = 8'h31 + 8'(i);
        check(ref_crc(fb, 9) === 32'hCBF43926, "R3 reference vector", ref_crc(fb, 9),
              32'hCBF43926);
        seal_fb(9);
        feed_rx(13, 3, 8'h00, "R1 R7 known vector, code 0x31");

        // transmit sweep over every padding amount, types 0, 1 and others
        for (int n = 1; n <= 9; n++) run_tx(n, 8'(n % 3));
        run_tx(12, 8'h01);

        // every type code in a correct 8-byte frame
        for (int t = 0; t < 256; t++) begin
            fb[0] = 8'(t); fb[1] = 8'h00; fb[2] = 8'h00; fb[3] = 8'h00;
            seal_fb(4);
            feed_rx(8, (t < 2) ? 0 : 3, 8'(t), $sformatf("R1 R8 type sweep t=%0d", t));
        end

        // short frames whose trailers are otherwise correct
        for (int n = 1; n <= 7; n++) begin
            fb[0] = 8'h00;
            for (int i = 1; i < 4; i++) fb[i] = 8'(i);
            if (n > 4) seal_fb(n - 4);
            feed_rx(n, 1, 8'h00, $sformatf("R6 short n=%0d", n));
        end

        // every single-bit corruption of a valid echo request frame
        for (int b = 0; b < 64; b++) begin
            fb[0] = 8'h00; fb[1] = 8'h00; fb[2] = 8'h00; fb[3] = 8'h00;
            seal_fb(4);
            fb[b/8][b%8] = ~fb[b/8][b%8];
            feed_rx(8, 2, 8'h00, $sformatf("R7 R8 flip bit=%0d", b));
        end

        // longer valid echo reply
        for (int i = 0; i < 16; i++) fb[i] = (i == 0) ? 8'h01 : 8'(i * 11);
        seal_fb(16);
        feed_rx(20, 0, 8'h01, "R8 long frame");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule